// File: doc/BRIEF.md
# Pulse Bin Accumulator and Phase Search

This block takes a receiver output that has already been synchronised to the system clock. It samples that output once per 1 kHz sample strobe and counts the high samples into a ring of 10 ms bins. The ring covers one second. When the final sample of the last bin arrives, the block copies the whole ring into a snapshot and raises a one-cycle second strobe. It then searches the snapshot for the bin offset where the once-per-second carrier pulse begins.

Each candidate offset gets a correlation score. The score is the sum of the pulse-width bins that start at the offset, minus the sum of all the other bins. The score is accumulated one bin per clock. While the block is unlocked it tries every offset. After a downstream bit classifier asserts the lock request, it tries only a narrow window around the current phase. A search winner replaces the held phase only if its score plus a fixed margin beats the score stored for the held phase. This hysteresis keeps a noisy second from moving a good phase. A restart request forgets the stored score and drops the lock.

Top module: `pulse_phase_search`

## Requirements
- R1: After reset, `phase` is 0, `locked`, `busy` and `sec_done` are 0, and the stored best score is the most negative 16-bit value.
- R2: On each `tick`, the current bin gains 1 if `rx_bit` is 1. A bin takes 10 ticks, 100 bins form the ring, and a bin starts from zero at its first tick of each pass. So a bin ends a pass holding the number of high samples in its 10 ticks.
- R3: `sec_done` is high for exactly one cycle, in the cycle after the edge that samples the 10th tick of bin 99. It pulses exactly once per 1000 ticks.
- R4: `busy` rises on the edge after `sec_done`. The score of an offset is the sum of the 10 bins starting there (modulo 100) minus the sum of the other 90. The first offset in search order with the strictly highest score wins.
- R5: While unlocked, offsets 0 to 99 are tried in ascending order, and `busy` stays high for 100*100+1 = 10001 cycles.
- R6: While locked, as sampled when the search starts, the 10 offsets from phase-5 up to phase+4 (modulo 100) are tried in that order, and `busy` stays high for 10*100+1 = 1001 cycles. `phase` is always below 100.
- R7: At the edge where `busy` falls, the winner replaces `phase` and the stored best score if its score plus 40 is strictly greater than the stored best score. Otherwise `phase` and the stored score keep their values. `phase` changes at no other edge.
- R8: A `lock_set` pulse sets `locked`. A `restart` pulse clears `locked` and sets the stored best score to the most negative value. If both arrive in the same cycle, `restart` wins; it also discards a search result that completes in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle sample strobe at 1 kHz |
| rx_bit | input | 1 | Synchronised receiver output |
| restart | input | 1 | Forget the stored score and drop the lock |
| lock_set | input | 1 | Lock request from the bit classifier |
| sec_done | output | 1 | One-cycle pulse per completed second of bins |
| busy | output | 1 | Phase search in progress |
| locked | output | 1 | Narrow-window search mode active |
| phase | output | 7 | Held pulse start bin index (0 to 99) |

## Verification
`sec_done` is due in the cycle after the edge that samples the last tick of a second. `busy` is due one edge later. From then on the bench counts the cycles `busy` stays high: 10001 for a full sweep and 1001 for a windowed one. `phase` is read in the first cycle after `busy` falls, because the hysteresis update lands on that same edge. Inputs are driven and outputs sampled only on falling clock edges. Ticks pause while a search runs, so every count is taken against a fixed reference edge.

// File: rtl/pb_pkg.sv
package pb_pkg;

    typedef logic signed [15:0] score_t;
    typedef logic signed [16:0] score_ext_t;

    localparam score_t SCORE_MIN = 16'sh8000;

    typedef enum logic [1:0] {
        SRCH_IDLE = 2'd0,
        SRCH_RUN  = 2'd1,
        SRCH_DONE = 2'd2
    } srch_state_e;

    typedef struct packed {
        score_t score;
        logic   better;
    } cand_t;

    function automatic score_ext_t widen(input score_t s);
        return score_ext_t'(s);
    endfunction

endpackage

// File: rtl/pb_bin_ring.sv
module pb_bin_ring #(
    parameter int NUM_BINS        = 100,
    parameter int SAMPLES_PER_BIN = 10,
    parameter int CNT_W           = 4,
    parameter int IDX_W           = 7
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             tick,
    input  logic                             rx_bit,
    output logic [NUM_BINS-1:0][CNT_W-1:0]   snap,
    output logic                             frame_done
);
    localparam int SC_W = $clog2(SAMPLES_PER_BIN + 1);

    logic [NUM_BINS-1:0][CNT_W-1:0] bins_q;
    logic [NUM_BINS-1:0][CNT_W-1:0] snap_d;
    logic [IDX_W-1:0]               wr_idx;
    logic [SC_W-1:0]                smp_cnt;
    logic                           last_smp, last_bin, wrap_now;

    assign last_smp = (smp_cnt == SC_W'(SAMPLES_PER_BIN - 1));
    assign last_bin = (wr_idx == IDX_W'(NUM_BINS - 1));
    assign wrap_now = tick && last_smp && last_bin;

    // Snapshot view: bin (NUM_BINS-1) already holds its final sample.
    for (genvar g = 0; g < NUM_BINS; g++) begin : g_snap
        if (g == NUM_BINS - 1) begin : g_tail
            assign snap_d[g] = bins_q[g] + CNT_W'(rx_bit);
        end else begin : g_body
            assign snap_d[g] = bins_q[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bins_q     <= '0;
            snap       <= '0;
            wr_idx     <= '0;
            smp_cnt    <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= wrap_now;
            if (wrap_now) begin
                snap <= snap_d;
            end
            if (tick) begin
                if (smp_cnt == '0) begin
                    bins_q[wr_idx] <= CNT_W'(rx_bit);
                end else begin
                    bins_q[wr_idx] <= bins_q[wr_idx] + CNT_W'(rx_bit);
                end
                if (last_smp) begin
                    smp_cnt <= '0;
                    wr_idx  <= last_bin ? '0 : wr_idx + 1'b1;
                end else begin
                    smp_cnt <= smp_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pb_corr_search.sv
module pb_corr_search
    import pb_pkg::*;
#(
    parameter int NUM_BINS  = 100,
    parameter int WIN_BINS  = 10,
    parameter int LOCK_SPAN = 10,
    parameter int LOCK_BACK = 5,
    parameter int CNT_W     = 4,
    parameter int IDX_W     = 7
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           start,
    input  logic                           locked,
    input  logic [IDX_W-1:0]               cur_phase,
    input  logic [NUM_BINS-1:0][CNT_W-1:0] snap,
    output logic                           busy,
    output logic                           res_valid,
    output score_t                         res_score,
    output logic [IDX_W-1:0]               res_offset
);
    localparam int OFF_W = $clog2(NUM_BINS + 1);

    srch_state_e      state;
    logic             mode_q;
    logic [OFF_W-1:0] off_cnt;
    logic [IDX_W-1:0] k_q, rd_ptr, cur_off, best_off;
    score_t           acc, best_score, term, acc_nx;
    logic [IDX_W:0]   base_sum;
    logic [IDX_W-1:0] base;
    logic             sweep_end, last_off;
    cand_t            cand;

    function automatic logic [IDX_W-1:0] nxt(input logic [IDX_W-1:0] v);
        return (v == IDX_W'(NUM_BINS - 1)) ? '0 : v + 1'b1;
    endfunction

    // Window start: phase - LOCK_BACK modulo NUM_BINS, or 0 when unlocked.
    assign base_sum = {1'b0, cur_phase} + (IDX_W + 1)'(NUM_BINS - LOCK_BACK);
    always_comb begin
        if (!locked) begin
            base = '0;
        end else if (base_sum >= (IDX_W + 1)'(NUM_BINS)) begin
            base = IDX_W'(base_sum - (IDX_W + 1)'(NUM_BINS));
        end else begin
            base = IDX_W'(base_sum);
        end
    end

    assign term      = (k_q < IDX_W'(WIN_BINS)) ? score_t'(snap[rd_ptr])
                                                 : -score_t'(snap[rd_ptr]);
    assign acc_nx    = acc + term;
    assign sweep_end = (k_q == IDX_W'(NUM_BINS - 1));
    assign last_off  = mode_q ? (off_cnt == OFF_W'(LOCK_SPAN - 1))
                              : (off_cnt == OFF_W'(NUM_BINS - 1));
    assign cand.score  = acc_nx;
    assign cand.better = (acc_nx > best_score);

    assign busy       = (state != SRCH_IDLE);
    assign res_valid  = (state == SRCH_DONE);
    assign res_score  = best_score;
    assign res_offset = best_off;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SRCH_IDLE;
            mode_q     <= 1'b0;
            off_cnt    <= '0;
            k_q        <= '0;
            rd_ptr     <= '0;
            cur_off    <= '0;
            best_off   <= '0;
            acc        <= '0;
            best_score <= SCORE_MIN;
        end else if (start) begin
            state      <= SRCH_RUN;
            mode_q     <= locked;
            off_cnt    <= '0;
            k_q        <= '0;
            rd_ptr     <= base;
            cur_off    <= base;
            best_off   <= base;
            acc        <= '0;
            best_score <= SCORE_MIN;
        end else begin
            case (state)
                SRCH_RUN: begin
                    if (sweep_end) begin
                        if (cand.better) begin
                            best_score <= cand.score;
                            best_off   <= cur_off;
                        end
                        acc     <= '0;
                        k_q     <= '0;
                        cur_off <= nxt(cur_off);
                        rd_ptr  <= nxt(cur_off);
                        off_cnt <= off_cnt + 1'b1;
                        if (last_off) begin
                            state <= SRCH_DONE;
                        end
                    end else begin
                        acc    <= acc_nx;
                        k_q    <= k_q + 1'b1;
                        rd_ptr <= nxt(rd_ptr);
                    end
                end
                SRCH_DONE: state <= SRCH_IDLE;
                default:   state <= SRCH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pb_phase_hold.sv
module pb_phase_hold
    import pb_pkg::*;
#(
    parameter int IDX_W  = 7,
    parameter int MARGIN = 40
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             lock_set,
    input  logic             res_valid,
    input  score_t           res_score,
    input  logic [IDX_W-1:0] res_offset,
    output logic [IDX_W-1:0] phase,
    output logic             locked
);
    score_t     best_q;
    score_ext_t lifted;
    logic       accept;

    assign lifted = widen(res_score) + score_ext_t'(MARGIN);
    assign accept = res_valid && (lifted > widen(best_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= '0;
            locked <= 1'b0;
            best_q <= SCORE_MIN;
        end else if (restart) begin
            locked <= 1'b0;
            best_q <= SCORE_MIN;
        end else begin
            if (lock_set) begin
                locked <= 1'b1;
            end
            if (accept) begin
                phase  <= res_offset;
                best_q <= res_score;
            end
        end
    end

endmodule

// File: rtl/pulse_phase_search.sv
module pulse_phase_search
    import pb_pkg::*;
#(
    parameter int NUM_BINS        = 100,
    parameter int SAMPLES_PER_BIN = 10,
    parameter int WIN_BINS        = 10,
    parameter int LOCK_SPAN       = 10,
    parameter int LOCK_BACK       = 5,
    parameter int MARGIN          = 40,
    localparam int IDX_W          = $clog2(NUM_BINS),
    localparam int CNT_W          = $clog2(SAMPLES_PER_BIN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             rx_bit,
    input  logic             restart,
    input  logic             lock_set,
    output logic             sec_done,
    output logic             busy,
    output logic             locked,
    output logic [IDX_W-1:0] phase
);
    logic [NUM_BINS-1:0][CNT_W-1:0] snap;
    logic                           res_valid;
    score_t                         res_score;
    logic [IDX_W-1:0]               res_offset;

    pb_bin_ring #(
        .NUM_BINS(NUM_BINS), .SAMPLES_PER_BIN(SAMPLES_PER_BIN),
        .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) u_ring (
        .clk(clk), .rst(rst), .tick(tick), .rx_bit(rx_bit),
        .snap(snap), .frame_done(sec_done)
    );

    pb_corr_search #(
        .NUM_BINS(NUM_BINS), .WIN_BINS(WIN_BINS), .LOCK_SPAN(LOCK_SPAN),
        .LOCK_BACK(LOCK_BACK), .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) u_search (
        .clk(clk), .rst(rst), .start(sec_done), .locked(locked),
        .cur_phase(phase), .snap(snap), .busy(busy),
        .res_valid(res_valid), .res_score(res_score), .res_offset(res_offset)
    );

    pb_phase_hold #(
        .IDX_W(IDX_W), .MARGIN(MARGIN)
    ) u_hold (
        .clk(clk), .rst(rst), .restart(restart), .lock_set(lock_set),
        .res_valid(res_valid), .res_score(res_score), .res_offset(res_offset),
        .phase(phase), .locked(locked)
    );

endmodule

// File: rtl/pulse_phase_search_chk.sv
module pulse_phase_search_chk #(
    parameter int NUM_BINS = 100,
    parameter int IDX_W    = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             restart,
    input logic             lock_set,
    input logic             sec_done,
    input logic             busy,
    input logic             locked,
    input logic [IDX_W-1:0] phase
);
    localparam int BUSY_LIMIT = NUM_BINS * NUM_BINS + 1;

    int busy_len;

    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            busy_len <= 0;
        end else begin
            busy_len <= busy_len + 1;
        end
    end

    assert_sec_single_R3: assert property (@(posedge clk) disable iff (rst)
        sec_done |=> !sec_done);

    assert_busy_follows_R4: assert property (@(posedge clk) disable iff (rst)
        sec_done |=> busy);

    assert_busy_bound_R5: assert property (@(posedge clk) disable iff (rst)
        (!busy && busy_len != 0) |-> (busy_len <= BUSY_LIMIT));

    assert_phase_range_R6: assert property (@(posedge clk) disable iff (rst)
        phase < IDX_W'(NUM_BINS));

    assert_phase_on_fall_R7: assert property (@(posedge clk) disable iff (rst)
        (phase != $past(phase)) |-> ($past(busy) && !busy));

    assert_restart_unlock_R8: assert property (@(posedge clk) disable iff (rst)
        restart |=> !locked);

    assert_lock_set_R8: assert property (@(posedge clk) disable iff (rst)
        (lock_set && !restart) |=> locked);

endmodule

bind pulse_phase_search pulse_phase_search_chk #(
    .NUM_BINS(NUM_BINS), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst(rst), .restart(restart), .lock_set(lock_set),
    .sec_done(sec_done), .busy(busy), .locked(locked), .phase(phase)
);

// File: tb/pulse_phase_search_tb.sv
`timescale 1ns/1ps
module pulse_phase_search_tb;

    localparam int TICK_GAP = 6;
    localparam int FULL_BUSY = 10001;
    localparam int WIN_BUSY  = 1001;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       rx_bit = 1'b0;
    logic       restart = 1'b0;
    logic       lock_set = 1'b0;
    logic       sec_done, busy, locked;
    logic [6:0] phase;

    int n_checks = 0;
    int n_fail   = 0;
    int n_pulses = 0;
    int n_seconds = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    pulse_phase_search u_dut (
        .clk(clk), .rst(rst), .tick(tick), .rx_bit(rx_bit),
        .restart(restart), .lock_set(lock_set),
        .sec_done(sec_done), .busy(busy), .locked(locked), .phase(phase)
    );

    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (!rst && sec_done) n_pulses <= n_pulses + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick_once(input logic s);
        @(negedge clk);
        tick = 1'b1; rx_bit = s;
        @(negedge clk);
        tick = 1'b0;
        repeat (TICK_GAP - 2) @(negedge clk);
    endtask

    function automatic logic sample_at(input int ms, input int start_bin, input int level);
        int bin = ms / 10;
        int rel = (bin - start_bin + 100) % 100;
        return (rel < 10) && ((ms % 10) < level);
    endfunction

    // One second of ticks, then time the search and read the result.
    task automatic run_second(input string req, input int start_bin, input int level,
                              input int exp_busy, input int exp_phase);
        int blen;
        for (int ms = 0; ms < 999; ms++) tick_once(sample_at(ms, start_bin, level));
        check({req, " R3 no early strobe"}, n_pulses, n_seconds);
        @(negedge clk);
        tick = 1'b1; rx_bit = sample_at(999, start_bin, level);
        @(negedge clk);
        tick = 1'b0;
        check({req, " R3 strobe high"}, int'(sec_done), 1);
        @(negedge clk);
        check({req, " R3 strobe single"}, int'(sec_done), 0);
        check({req, " R4 busy rise"}, int'(busy), 1);
        blen = 1;
        while (busy) begin
            @(negedge clk);
            if (busy) blen++;
        end
        n_seconds++;
        check({req, " busy length"}, blen, exp_busy);
        check({req, " phase"}, int'(phase), exp_phase);
        check({req, " R3 one strobe per second"}, n_pulses, n_seconds);
    endtask

    task automatic pulse_lock();
        @(negedge clk); lock_set = 1'b1;
        @(negedge clk); lock_set = 1'b0;
        check("R8 lock_set", int'(locked), 1);
    endtask

    task automatic test_reset();
        check("R1 phase", int'(phase), 0);
        check("R1 locked", int'(locked), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 sec_done", int'(sec_done), 0);
    endtask

    // R2 R4 R5: full pulse at bin 30, unlocked sweep.
    task automatic test_unlocked_full();
        run_second("R5 R2 full pulse 30", 30, 10, FULL_BUSY, 30);
    endtask

    // R7: weak second (score 50, 50+40 <= 100) must not move the phase.
    task automatic test_hyst_reject();
        run_second("R7 reject weak 60", 60, 5, FULL_BUSY, 30);
    endtask

    // R7: score 70, 70+40 > 100 is accepted; bins were cleared (R2).
    task automatic test_hyst_accept();
        run_second("R7 R2 accept 60", 60, 7, FULL_BUSY, 60);
    endtask

    // R6: locked window 55..64 contains 63.
    task automatic test_locked_inside();
        pulse_lock();
        run_second("R6 window hit 63", 63, 10, WIN_BUSY, 63);
    endtask

    // R6 R7: pulse at 20 lies outside 58..67; every score is -100, rejected.
    task automatic test_locked_outside();
        run_second("R6 window miss 20", 20, 10, WIN_BUSY, 63);
    endtask

    // R8: restart unlocks and forgets the score, so a weak pulse is accepted.
    task automatic test_restart();
        @(negedge clk); restart = 1'b1; lock_set = 1'b1;
        @(negedge clk); restart = 1'b0; lock_set = 1'b0;
        check("R8 restart beats lock_set", int'(locked), 0);
        run_second("R8 weak after restart 98", 98, 5, FULL_BUSY, 98);
    endtask

    // R6: window 93..2 wraps through bin 0; then window 97..6 picks 97 (score 80).
    task automatic test_locked_wrap();
        pulse_lock();
        run_second("R6 wrap window 2", 2, 10, WIN_BUSY, 2);
        run_second("R6 wrap window 96", 96, 10, WIN_BUSY, 97);
        check("R6 still locked", int'(locked), 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_unlocked_full();
        test_hyst_reject();
        test_hyst_accept();
        test_locked_inside();
        test_locked_outside();
        test_restart();
        test_locked_wrap();
        done = 1'b1;
    end

    initial begin
        while (!done && cycles < 195000) @(negedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule